// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master for external PHYs using IEEE 802.3 Clause 45 indirect frames. A host reaches it through a small 32-bit register port with four word registers: status, control, data and address. The block divides the system clock to produce MDC. It drives the shared MDIO wire through a separate output and output enable, and it reads the wire back through an input.

A complete indirect access takes two frames. The host first selects the PHY port and the device inside it in the control register. Writing a register number to the address register sends an address frame. The host then starts the second frame in one of two ways. Writing the data register sends a write frame. Writing the control register with its read bit set sends a read frame, and the returned 16 bits appear in the data register. The host follows progress through two busy flags: a general one in the status register and a data-path one in the data register. A read that gets no response from the PHY raises an error flag.

A host register write is a single-cycle strobe. No access waits, and reads return data combinationally. No frames are queued, so any write that arrives while a frame is running is dropped.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset the status register (offset 0x0) reads 0x0000_0640, which is divider 100 in bits [11:4] with busy bit 0 and error bit 1 both clear. The control and data registers read zero, and MDC and the MDIO output enable are low.
- R2: A control write (offset 0x4) stores the port address from bits [12:8] and the device address from bits [4:0]. Control reads back only those fields; bit 15 and every other bit read 0. A status write stores bits [11:4] as the divider, and the status register reads the divider back in the same place. The address register (offset 0xC) reads zero.
- R3: Writing the address register while idle sends one 64-bit frame, MSB first. The frame is 32 ones, then 00, then opcode 00, then the 5-bit port address, the 5-bit device address, the turnaround 10 and bits [15:0] of the write. From the next cycle status bit 0 reads 1 and data bit 31 reads 0.
- R4: Writing the data register (offset 0x8) while idle stores bits [15:0] and sends the same frame layout with opcode 01 and that value as the payload. Data bit 31 and status bit 0 both read 1 until the frame ends.
- R5: A control write with bit 15 set while idle sends a frame with opcode 11. The output enable is low for the two turnaround bits and the 16 data bits. The bits sampled on those 16 MDC rising edges, MSB first, land in data bits [15:0] when the frame ends.
- R6: If MDIO samples 1 on the rising edge of the second turnaround bit of a read, status bit 1 is set. Starting any new frame clears it.
- R7: Each MDC half period lasts exactly divider+1 system clocks. Every frame has exactly 64 MDC rising edges. MDIO changes only on MDC falling edges and is sampled on rising edges.
- R8: While any frame is running, writes to all four registers are ignored. This includes a write in the cycle right after the launching write. Such a write changes no stored field and starts no frame.
- R9: Both busy flags drop in the cycle after the falling edge that ends bit 63. While idle, MDC and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
Two events can fall in the same cycle: a launching register write, and a second write that lands one cycle later while the frame engine has just gone busy. The bench provokes this by issuing an address write and a data write with all ones back to back, with no idle cycle between them. It then sprays all four registers with all-ones writes while the frame is still running. The bench judges the outcome after the frame: exactly 64 MDC rising edges must have occurred, and the control fields, divider and data register must still hold their earlier values. The second coincidence is the read result being captured in the same cycle that the busy flags drop. This is checked by reading the data register as soon as busy is seen clear.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mgmt_op_e;

  typedef struct packed {
    mgmt_op_e    op;
    logic [4:0]  prt;
    logic [4:0]  dev;
    logic [15:0] payload;
  } mgmt_cmd_t;

  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_DATA = 4'h8;
  localparam logic [3:0] OFS_ADDR = 4'hC;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_DIV_LSB  = 4;
  localparam int CTRL_RD_BIT   = 15;
  localparam int CTRL_PRT_LSB  = 8;
  localparam int CTRL_DEV_LSB  = 0;
  localparam int DATA_BUSY_BIT = 31;

  // Serial image of one management frame, first bit in the MSB.
  function automatic logic [FRAME_BITS-1:0] frame_word(mgmt_cmd_t c);
    return {{32{1'b1}}, 2'b00, c.op, c.prt, c.dev, 2'b10, c.payload};
  endfunction

endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = run && (cnt_q == div);
  assign rise_p = wrap && !mdc;
  assign fall_p = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_c45_frame.sv
module mdio_c45_frame
  import mdio_c45_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        rise_p,
  input  logic        fall_p,
  input  logic        mdio_i,
  output logic        active,
  output mgmt_op_e    op_q,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_err,
  output logic        done,
  output logic [15:0] rx_data
);

  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  last_bit;
  logic                  is_rd;
  logic                  released;

  assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign is_rd    = (op_q == OP_READ);
  assign released = is_rd && (idx_q >= IDX_W'(TA_FIRST));
  assign done     = active && fall_p && last_bit;
  assign mdio_o   = sh_q[FRAME_BITS-1];
  assign mdio_oe  = active && !released;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      op_q    <= OP_ADDR;
      sh_q    <= '0;
      idx_q   <= '0;
      rd_err  <= 1'b0;
      rx_data <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      op_q   <= cmd.op;
      sh_q   <= frame_word(cmd);
      idx_q  <= '0;
      rd_err <= 1'b0;
    end else if (active) begin
      if (rise_p && is_rd) begin
        if (idx_q == IDX_W'(TA_FIRST + 1)) rd_err <= mdio_i;
        if (idx_q >= IDX_W'(DATA_FIRST)) rx_data <= {rx_data[14:0], mdio_i};
      end
      if (fall_p) begin
        if (last_bit) begin
          active <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             eng_active,
  input  mgmt_op_e         eng_op,
  input  logic             eng_err,
  input  logic             eng_done,
  input  logic [15:0]      eng_rx,
  output logic             start,
  output mgmt_cmd_t        cmd,
  output logic [DIV_W-1:0] div,
  output logic             data_busy
);

  logic [DIV_W-1:0] div_q;
  logic [4:0]       prt_q;
  logic [4:0]       dev_q;
  logic [15:0]      data_q;
  logic             wr_ok;
  logic             unused_wbits;

  assign wr_ok        = reg_wr && !eng_active;
  assign div          = div_q;
  assign data_busy    = eng_active && (eng_op != OP_ADDR);
  assign unused_wbits = ^reg_wdata[31:16];

  // Launch decode: each frame starts as a side effect of one register write.
  always_comb begin
    start       = 1'b0;
    cmd.op      = OP_ADDR;
    cmd.prt     = prt_q;
    cmd.dev     = dev_q;
    cmd.payload = reg_wdata[15:0];
    if (wr_ok) begin
      case (reg_addr)
        OFS_CTRL: begin
          if (reg_wdata[CTRL_RD_BIT]) begin
            start       = 1'b1;
            cmd.op      = OP_READ;
            cmd.prt     = reg_wdata[CTRL_PRT_LSB +: 5];
            cmd.dev     = reg_wdata[CTRL_DEV_LSB +: 5];
            cmd.payload = 16'hFFFF;
          end
        end
        OFS_DATA: begin
          start  = 1'b1;
          cmd.op = OP_WRITE;
        end
        OFS_ADDR: begin
          start  = 1'b1;
          cmd.op = OP_ADDR;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_RESET);
      prt_q  <= '0;
      dev_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          OFS_STAT: div_q <= reg_wdata[STAT_DIV_LSB +: DIV_W];
          OFS_CTRL: begin
            prt_q <= reg_wdata[CTRL_PRT_LSB +: 5];
            dev_q <= reg_wdata[CTRL_DEV_LSB +: 5];
          end
          OFS_DATA: data_q <= reg_wdata[15:0];
          default: ;
        endcase
      end
      if (eng_done && eng_op == OP_READ) data_q <= eng_rx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STAT: begin
        reg_rdata[STAT_BUSY_BIT]            = eng_active;
        reg_rdata[STAT_ERR_BIT]             = eng_err;
        reg_rdata[STAT_DIV_LSB +: DIV_W]    = div_q;
      end
      OFS_CTRL: begin
        reg_rdata[CTRL_PRT_LSB +: 5] = prt_q;
        reg_rdata[CTRL_DEV_LSB +: 5] = dev_q;
      end
      OFS_DATA: begin
        reg_rdata[DATA_BUSY_BIT] = data_busy;
        reg_rdata[15:0]          = data_q;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic             frame_active;
  logic             data_busy;
  logic [DIV_W-1:0] div_val;
  logic             start;
  mgmt_cmd_t        cmd;
  mgmt_op_e         eng_op;
  logic             rd_err;
  logic             eng_done;
  logic [15:0]      rx_data;
  logic             rise_p;
  logic             fall_p;

  mdio_c45_regs #(
    .DIV_W     (DIV_W),
    .DIV_RESET (DIV_RESET)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_active (frame_active),
    .eng_op     (eng_op),
    .eng_err    (rd_err),
    .eng_done   (eng_done),
    .eng_rx     (rx_data),
    .start      (start),
    .cmd        (cmd),
    .div        (div_val),
    .data_busy  (data_busy)
  );

  mdio_c45_clkgen #(
    .DIV_W (DIV_W)
  ) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (frame_active),
    .div    (div_val),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_c45_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cmd     (cmd),
    .rise_p  (rise_p),
    .fall_p  (fall_p),
    .mdio_i  (mdio_i),
    .active  (frame_active),
    .op_q    (eng_op),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_err  (rd_err),
    .done    (eng_done),
    .rx_data (rx_data)
  );

endmodule

// File: rtl/mdio_c45_master_chk.sv
module mdio_c45_master_chk
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [3:0]       reg_addr,
  input logic             frame_active,
  input logic             data_busy,
  input logic [DIV_W-1:0] div_val,
  input logic             mdc,
  input logic             mdio_oe
);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> (!mdc && !mdio_oe));

  assert_addr_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !frame_active && reg_addr == OFS_ADDR) |=> (frame_active && !data_busy));

  assert_write_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !frame_active && reg_addr == OFS_DATA) |=> data_busy);

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && data_busy && !mdio_oe) |=> !mdio_oe);

  assert_mdc_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && div_val != '0 && !$stable(mdc)) |=> $stable(mdc));

  assert_div_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && frame_active && reg_addr == OFS_STAT) |=> $stable(div_val));

endmodule

bind mdio_c45_master mdio_c45_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .frame_active (frame_active),
  .data_busy    (data_busy),
  .div_val      (div_val),
  .mdc          (mdc),
  .mdio_oe      (mdio_oe)
);

// File: tb/mdio_c45_master_bench.sv
module mdio_c45_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mdio_c45_master u_mdio_c45_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  // PHY-side observer and responder
  logic [63:0] cap;
  logic [63:0] cap_oe;
  int          rises;
  int          fidx;
  bit          phy_rd;
  bit          phy_ta_bad;
  logic [15:0] phy_resp;
  int          cyc = 0;
  int          last_t;
  bit          have_last = 1'b0;
  int          half_bad;
  int          cur_div = 100;
  logic [15:0] model_data = '0;

  always @(negedge clk) cyc++;

  always @(posedge mdc) begin
    cap    = {cap[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rises++;
  end

  always @(negedge mdc) begin
    fidx++;
    if (phy_rd && fidx == 47)                 mdio_i = phy_ta_bad;
    else if (phy_rd && fidx >= 48 && fidx <= 63) mdio_i = phy_resp[63 - fidx];
    else                                      mdio_i = 1'b1;
  end

  always @(mdc) begin
    if (have_last && (cyc - last_t) != cur_div + 1) half_bad++;
    last_t    = cyc;
    have_last = 1'b1;
  end

  function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] prt,
                                            logic [4:0] dev, logic [15:0] pl);
    return {32'hFFFF_FFFF, 2'b00, op, prt, dev, 2'b10, pl};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 40000; k++) begin
      bus_read(4'h0, s);
      if (!s[0]) return;
    end
    chk(1'b0, "R9 busy never cleared", 64'(s), 64'h0);
  endtask

  task automatic do_frame(input logic [1:0] op, input logic [4:0] prt,
                          input logic [4:0] dev, input logic [15:0] val,
                          input int div, input bit ta_bad, input bit jam);
    logic [31:0] r;
    logic [63:0] ef;
    bus_write(4'h0, 32'(div) << 4);
    cur_div = div;
    bus_write(4'h4, {16'h0, 3'b0, prt, 3'b0, dev});
    cap = '0; cap_oe = '0; rises = 0; fidx = 0; half_bad = 0;
    have_last = 1'b0;
    phy_rd = (op == 2'b11); phy_ta_bad = ta_bad; phy_resp = val;
    @(negedge clk);
    reg_wr = 1'b1;
    case (op)
      2'b00:   begin reg_addr = 4'hC; reg_wdata = {16'h0, val}; end
      2'b01:   begin reg_addr = 4'h8; reg_wdata = {16'h0, val}; end
      default: begin reg_addr = 4'h4; reg_wdata = {16'h0, 1'b1, 2'b0, prt, 3'b0, dev}; end
    endcase
    if (jam) begin
      @(negedge clk);
      reg_addr  = 4'h8;
      reg_wdata = 32'hFFFF_FFFF;
    end
    @(negedge clk);
    reg_wr = 1'b0;
    bus_read(4'h0, r);
    chk(r == ((32'(div) << 4) | 32'h1), "R3/R6 status busy set, error cleared at launch",
        64'(r), 64'((32'(div) << 4) | 32'h1));
    bus_read(4'h8, r);
    chk(r[31] == (op != 2'b00), "R4 data busy flag during frame", 64'(r[31]), 64'(op != 2'b00));
    if (jam) begin
      bus_write(4'h0, 32'hFFFF_FFFF);
      bus_write(4'h4, 32'hFFFF_FFFF);
      bus_write(4'h8, 32'hFFFF_FFFF);
      bus_write(4'hC, 32'hFFFF_FFFF);
    end
    wait_idle();
    if (op == 2'b01) model_data = val;
    if (op == 2'b11) model_data = val;
    chk(rises == 64, "R7/R8 exactly 64 MDC rising edges", 64'(rises), 64'd64);
    chk(half_bad == 0, "R7 MDC half period equals divider+1", 64'(half_bad), 64'd0);
    ef = exp_frame(op, prt, dev, val);
    if (op == 2'b11) begin
      chk(cap[63:18] == ef[63:18], "R5 read frame header", 64'(cap[63:18]), 64'(ef[63:18]));
      chk(cap_oe == {{46{1'b1}}, 18'h0}, "R5 output enable released for turnaround and data",
          cap_oe, {{46{1'b1}}, 18'h0});
      bus_read(4'h0, r);
      chk(r[1] == ta_bad, "R6 read error flag", 64'(r[1]), 64'(ta_bad));
    end else begin
      chk(cap == ef, (op == 2'b00) ? "R3 address frame bits" : "R4 write frame bits", cap, ef);
      chk(cap_oe == '1, "R3 output enable held for whole frame", cap_oe, '1);
    end
    bus_read(4'h8, r);
    chk(r == {16'h0, model_data}, "R5/R4/R8 data register after frame", 64'(r),
        64'({16'h0, model_data}));
    bus_read(4'h4, r);
    chk(r == {16'h0, 3'b0, prt, 3'b0, dev}, "R8 control fields unchanged", 64'(r),
        64'({16'h0, 3'b0, prt, 3'b0, dev}));
    bus_read(4'h0, r);
    chk(r[11:4] == 8'(div), "R8 divider unchanged", 64'(r[11:4]), 64'(div));
    chk(!mdc && !mdio_oe, "R9 idle MDC and output enable low", 64'({mdc, mdio_oe}), 64'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(4'h0, r);
    chk(r == 32'h0000_0640, "R1 status after reset", 64'(r), 64'h640);
    bus_read(4'h4, r);
    chk(r == 32'h0, "R1 control after reset", 64'(r), 64'h0);
    bus_read(4'h8, r);
    chk(r == 32'h0, "R1 data after reset", 64'(r), 64'h0);
    chk(!mdc && !mdio_oe, "R1 MDC and output enable low", 64'({mdc, mdio_oe}), 64'h0);

    // R2 field layout and readback masking
    bus_write(4'h4, 32'hFFFF_7FFF);
    bus_read(4'h4, r);
    chk(r == 32'h0000_1F1F, "R2 control readback masked", 64'(r), 64'h1F1F);
    bus_write(4'h0, 32'h0000_0ABC);
    bus_read(4'h0, r);
    chk(r == 32'h0000_0AB0, "R2 divider field readback", 64'(r), 64'hAB0);
    bus_read(4'hC, r);
    chk(r == 32'h0, "R2 address register reads zero", 64'(r), 64'h0);
    chk(!mdc && !mdio_oe && rst_n, "R2 no frame from control write without read bit",
        64'({mdc, mdio_oe}), 64'h0);

    // Directed frames
    do_frame(2'b00, 5'h01, 5'h1E, 16'h8001, 100, 1'b0, 1'b0); // R7 full divider
    do_frame(2'b01, 5'h1F, 5'h00, 16'hA55A, 0, 1'b0, 1'b0);   // R4 fastest MDC
    do_frame(2'b11, 5'h0A, 5'h15, 16'h3C96, 1, 1'b0, 1'b0);   // R5 read
    do_frame(2'b11, 5'h11, 5'h03, 16'hFFFF, 2, 1'b1, 1'b0);   // R6 no responder
    do_frame(2'b00, 5'h05, 5'h07, 16'h1234, 1, 1'b0, 1'b0);   // R6 error cleared
    do_frame(2'b00, 5'h12, 5'h09, 16'h0F0F, 0, 1'b0, 1'b1);   // R8 back-to-back jam
    do_frame(2'b11, 5'h02, 5'h04, 16'h6001, 3, 1'b0, 1'b1);   // R8 jam during read

    // Constrained random frames
    for (int i = 0; i < 10; i++) begin
      logic [1:0] op;
      int sel;
      sel = int'($urandom % 3);
      op  = (sel == 0) ? 2'b00 : (sel == 1) ? 2'b01 : 2'b11;
      do_frame(op, 5'($urandom), 5'($urandom), 16'($urandom), int'($urandom % 4),
               (op == 2'b11) && ($urandom % 4 == 0), ($urandom % 3 == 0));
    end

    finish_run();
  end

endmodule